// File: doc/BRIEF.md
# Asynchronous Bus Write-Cycle Sequencer

This block is a bus master that performs one write transfer at a time on a 16-bit data bus with a 23-bit word address. The core hands it a request: address, data, function code and transfer size. The block then walks the bus through eight half-clock phases, S0 to S7, with one phase per period of the phase clock `clk`. Each output changes at a fixed phase. The function code is valid first. The address follows, then the address strobe with the write direction, then the write data, and finally the data strobes for the byte lanes in use.

The acknowledge and bus-error inputs are asynchronous. Each passes through a synchronizer. After S4, the sequencer stretches the transfer in whole bus-clock steps of two phases until one of these inputs is seen. A third asynchronous input, the legacy peripheral request, is only noted during S4 and reported when the cycle ends. The block asserts a single-cycle `done` in S7. With it, `done` carries a bus-error flag and the peripheral flag. The core may launch a new request only while `req_ready` is high.

Top module: `bus_write_seq`

## Requirements
- R1: After reset, `as_n`, `uds_n`, `lds_n` and `rw_o` are high, both data lane enables are low, `done` is low and `req_ready` is high.
- R2: A request is taken only when `req_valid` and `req_ready` are both high at a clock edge, and `req_ready` is high only while idle. A `req_valid` pulse during a running cycle changes neither the address, the data nor the cycle length.
- R3: Phases are counted from S0, the first cycle after acceptance. `fc_o` holds the request's function code from S0. `addr_o` holds the request address from S1. `as_n` and `rw_o` go low in S2. The lane enables rise in S3. The data strobes for the chosen lanes go low in S4.
- R4: `req_size` sets the lanes. 2'b00 is a word, using both lanes and both strobes. 2'b01 is an even byte, using only the upper lane `data_o[15:8]` with `data_oe_hi` and `uds_n`. 2'b10 is an odd byte, using only the lower lane `data_o[7:0]` with `data_oe_lo` and `lds_n`. 2'b11 behaves as a word.
- R5: A termination that is already synchronized by the end of S4 produces no wait states. The cycle then lasts 8 phases, and `done` is high for exactly one cycle, in S7.
- R6: Each termination input passes through a 2-flop synchronizer. Until a synchronized termination is seen at the end of S4, or at the end of a wait pair, the sequencer adds wait pairs of two phases. During each pair every bus output keeps its S4 value.
- R7: In S7, `as_n`, `uds_n` and `lds_n` are high again while address and data are still held. The lane enables fall on the edge that leaves S7. `rw_o` stays low until the next S0 drives it high.
- R8: A bus error ends the cycle with the same timing as an acknowledge, and `done_err` is high together with `done`. If both arrive at the same time, the error wins.
- R9: If the synchronized peripheral request is low during S4, `done_periph` is high with `done`; otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one period per half bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | High while idle and able to take a request |
| req_addr | input | 23 | Word address of the transfer |
| req_data | input | 16 | Write data, already placed in its lane |
| req_fc | input | 3 | Function code for the transfer |
| req_size | input | 2 | 00 word, 01 even byte, 10 odd byte, 11 word |
| done | output | 1 | One-cycle end-of-cycle pulse in S7 |
| done_err | output | 1 | The cycle ended on a bus error |
| done_periph | output | 1 | Peripheral request seen in S4 |
| bus_ack_n | input | 1 | Asynchronous acknowledge, active low |
| bus_err_n | input | 1 | Asynchronous bus error, active low |
| periph_req_n | input | 1 | Asynchronous legacy peripheral request, active low |
| fc_o | output | 3 | Function code on the bus |
| addr_o | output | 23 | Address bus |
| as_n | output | 1 | Address strobe, active low |
| rw_o | output | 1 | High for read, low for write |
| uds_n | output | 1 | Upper data strobe, active low |
| lds_n | output | 1 | Lower data strobe, active low |
| data_o | output | 16 | Write data |
| data_oe_hi | output | 1 | Drive enable for data_o[15:8] |
| data_oe_lo | output | 1 | Drive enable for data_o[7:0] |

## Verification
The assertions assume that `req_size` and the request fields are stable on the accepting edge. They also assume that a termination input, once asserted, stays asserted until `done`, and that it is released before the next request. The bench drives every input on the falling clock edge. It holds each acknowledge or error until it has seen `done`, and then waits several idle cycles so the synchronizers flush before it issues the next request. Arrival times of the termination inputs are chosen to land both before and after the S4 decision point. Those cases exercise zero, one and two wait pairs.

// File: rtl/bws_pkg.sv
package bws_pkg;
   typedef enum logic [3:0] {
      ST_IDLE = 4'd0,
      ST_S0   = 4'd1,
      ST_S1   = 4'd2,
      ST_S2   = 4'd3,
      ST_S3   = 4'd4,
      ST_S4   = 4'd5,
      ST_S5   = 4'd6,
      ST_S6   = 4'd7,
      ST_S7   = 4'd8,
      ST_WA   = 4'd9,
      ST_WB   = 4'd10
   } bws_state_e;

   typedef enum logic [1:0] {
      SZ_WORD = 2'b00,
      SZ_EVEN = 2'b01,
      SZ_ODD  = 2'b10,
      SZ_RSVD = 2'b11
   } bws_size_e;

   // {upper lane, lower lane}
   function automatic logic [1:0] lane_mask(input bws_size_e sz);
      case (sz)
         SZ_EVEN: lane_mask = 2'b10;
         SZ_ODD:  lane_mask = 2'b01;
         default: lane_mask = 2'b11;
      endcase
   endfunction

   // phases in which the address strobe is low
   function automatic logic as_phase(input bws_state_e st);
      case (st)
         ST_S2, ST_S3, ST_S4, ST_S5, ST_S6, ST_WA, ST_WB: as_phase = 1'b1;
         default: as_phase = 1'b0;
      endcase
   endfunction

   // phases in which the data strobes are low
   function automatic logic ds_phase(input bws_state_e st);
      case (st)
         ST_S4, ST_S5, ST_S6, ST_WA, ST_WB: ds_phase = 1'b1;
         default: ds_phase = 1'b0;
      endcase
   endfunction

   // phases in which the data lanes are driven
   function automatic logic oe_phase(input bws_state_e st);
      case (st)
         ST_S3, ST_S4, ST_S5, ST_S6, ST_S7, ST_WA, ST_WB: oe_phase = 1'b1;
         default: oe_phase = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/bws_sync.sv
module bws_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("bws_sync: STAGES must be in 0..4");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= {STAGES{RST_VAL}};
            end else begin
               sh[0] <= d;
               for (int k = 1; k < STAGES; k++) sh[k] <= sh[k-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bws_fsm.sv
module bws_fsm
   import bws_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       term_ack,
   input  logic       term_err,
   input  logic       periph_req,
   output bws_state_e state,
   output logic       done,
   output logic       done_err,
   output logic       done_periph
);
   bws_state_e nxt;
   logic       term_any;
   logic       decide;
   logic       err_q;
   logic       per_q;

   assign term_any = term_ack | term_err;
   assign decide   = (state == ST_S4) || (state == ST_WB);

   always_comb begin
      case (state)
         ST_IDLE: nxt = start ? ST_S0 : ST_IDLE;
         ST_S0:   nxt = ST_S1;
         ST_S1:   nxt = ST_S2;
         ST_S2:   nxt = ST_S3;
         ST_S3:   nxt = ST_S4;
         ST_S4:   nxt = term_any ? ST_S5 : ST_WA;
         ST_WA:   nxt = ST_WB;
         ST_WB:   nxt = term_any ? ST_S5 : ST_WA;
         ST_S5:   nxt = ST_S6;
         ST_S6:   nxt = ST_S7;
         ST_S7:   nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         err_q <= 1'b0;
         per_q <= 1'b0;
      end else begin
         state <= nxt;
         if (start && state == ST_IDLE) begin
            err_q <= 1'b0;
            per_q <= 1'b0;
         end else begin
            if (decide && term_err)              err_q <= 1'b1;
            if (state == ST_S4 && periph_req)    per_q <= 1'b1;
         end
      end
   end

   assign done        = (state == ST_S7);
   assign done_err    = done & err_q;
   assign done_periph = done & per_q;

   // a wait pair always ends at the second half
   p_wait_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WA) |=> (state == ST_WB));
   // the cycle never terminates without a termination input
   p_no_term_no_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && !term_ack && !term_err) |=> (state == ST_WA));
endmodule

// File: rtl/bws_drive.sv
module bws_drive
   import bws_pkg::*;
#(
   parameter int ADDR_W = 23,
   parameter int DATA_W = 16,
   parameter int FC_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  bws_state_e        state,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [FC_W-1:0]   req_fc,
   input  logic [1:0]        req_size,
   output logic [FC_W-1:0]   fc_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              as_n,
   output logic              rw_o,
   output logic              uds_n,
   output logic              lds_n,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe_hi,
   output logic              data_oe_lo
);
   localparam int LANE_W = DATA_W / 2;

   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;
   logic [FC_W-1:0]   cap_fc;
   bws_size_e         cap_size;
   logic [1:0]        lanes;
   logic              rw_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr <= '0;
         cap_data <= '0;
         cap_fc   <= '0;
         cap_size <= SZ_WORD;
      end else if (start && state == ST_IDLE) begin
         cap_addr <= req_addr;
         cap_data <= req_data;
         cap_fc   <= req_fc;
         cap_size <= bws_size_e'(req_size);
      end
   end

   // address changes on the edge that enters S1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                addr_q <= '0;
      else if (state == ST_S0)   addr_q <= cap_addr;
   end

   // direction: high entering S0, low entering S2, held otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             rw_q <= 1'b1;
      else if (start && state == ST_IDLE)     rw_q <= 1'b1;
      else if (state == ST_S1)                rw_q <= 1'b0;
   end

   assign lanes      = lane_mask(cap_size);
   assign fc_o       = cap_fc;
   assign addr_o     = addr_q;
   assign rw_o       = rw_q;
   assign as_n       = ~as_phase(state);
   assign uds_n      = ~(ds_phase(state) & lanes[1]);
   assign lds_n      = ~(ds_phase(state) & lanes[0]);
   assign data_oe_hi = oe_phase(state) & lanes[1];
   assign data_oe_lo = oe_phase(state) & lanes[0];

   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         assign data_o[g*LANE_W +: LANE_W] = cap_data[g*LANE_W +: LANE_W];
      end
   endgenerate

   p_upper_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_hi |=> (!data_oe_hi || $stable(data_o[DATA_W-1:LANE_W])));
   p_lower_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_lo |=> (!data_oe_lo || $stable(data_o[LANE_W-1:0])));
   p_strobe_has_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!uds_n |-> data_oe_hi) and (!lds_n |-> data_oe_lo));
   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !as_n |=> (as_n || $stable(addr_o)));
endmodule

// File: rtl/bus_write_seq.sv
module bus_write_seq
   import bws_pkg::*;
#(
   parameter int ADDR_W      = 23,
   parameter int DATA_W      = 16,
   parameter int FC_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [FC_W-1:0]   req_fc,
   input  logic [1:0]        req_size,
   output logic              done,
   output logic              done_err,
   output logic              done_periph,
   input  logic              bus_ack_n,
   input  logic              bus_err_n,
   input  logic              periph_req_n,
   output logic [FC_W-1:0]   fc_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              as_n,
   output logic              rw_o,
   output logic              uds_n,
   output logic              lds_n,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe_hi,
   output logic              data_oe_lo
);
   localparam int N_ASYNC = 3;

   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data
         $error("bus_write_seq: DATA_W must be even and at least 2");
      end
      if (ADDR_W < 1 || FC_W < 1) begin : g_bad_addr
         $error("bus_write_seq: ADDR_W and FC_W must be positive");
      end
   endgenerate

   logic [N_ASYNC-1:0] async_n;
   logic [N_ASYNC-1:0] sync_n;
   bws_state_e         state;
   logic               start;

   assign async_n = {periph_req_n, bus_err_n, bus_ack_n};

   generate
      for (genvar i = 0; i < N_ASYNC; i++) begin : g_sync
         bws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (async_n[i]),
            .q    (sync_n[i])
         );
      end
   endgenerate

   assign req_ready = (state == ST_IDLE);
   assign start     = req_valid & req_ready;

   bws_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .term_ack   (~sync_n[0]),
      .term_err   (~sync_n[1]),
      .periph_req (~sync_n[2]),
      .state      (state),
      .done       (done),
      .done_err   (done_err),
      .done_periph(done_periph)
   );

   bws_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W)) u_drive (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .state     (state),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .req_fc    (req_fc),
      .req_size  (req_size),
      .fc_o      (fc_o),
      .addr_o    (addr_o),
      .as_n      (as_n),
      .rw_o      (rw_o),
      .uds_n     (uds_n),
      .lds_n     (lds_n),
      .data_o    (data_o),
      .data_oe_hi(data_oe_hi),
      .data_oe_lo(data_oe_lo)
   );

   p_as_means_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !as_n |-> !rw_o);
   p_strobe_inside_as_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!uds_n || !lds_n) |-> !as_n);
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (as_n && uds_n && lds_n));
   p_ready_bus_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (as_n && !data_oe_hi && !data_oe_lo));
   p_flags_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_err || done_periph) |-> done);
endmodule

// File: tb/bus_write_seq_tb.sv
module bus_write_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [22:0] req_addr = '0;
   logic [15:0] req_data = '0;
   logic [2:0]  req_fc = '0;
   logic [1:0]  req_size = '0;
   logic        done, done_err, done_periph;
   logic        bus_ack_n = 1'b1;
   logic        bus_err_n = 1'b1;
   logic        periph_req_n = 1'b1;
   logic [2:0]  fc_o;
   logic [22:0] addr_o;
   logic        as_n, rw_o, uds_n, lds_n;
   logic [15:0] data_o;
   logic        data_oe_hi, data_oe_lo;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   bus_write_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_fc(req_fc), .req_size(req_size),
      .done(done), .done_err(done_err), .done_periph(done_periph),
      .bus_ack_n(bus_ack_n), .bus_err_n(bus_err_n), .periph_req_n(periph_req_n),
      .fc_o(fc_o), .addr_o(addr_o), .as_n(as_n), .rw_o(rw_o),
      .uds_n(uds_n), .lds_n(lds_n), .data_o(data_o),
      .data_oe_hi(data_oe_hi), .data_oe_lo(data_oe_lo)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // One write cycle; d = negedge index after S0 at which termination is driven.
   task automatic run_cycle(input logic [1:0] sz, input logic [22:0] a, input logic [15:0] dat,
                            input logic [2:0] f, input int d, input bit use_err,
                            input bit periph, input bit inject);
      bit up, lo;
      int waits, len;
      up = (sz != 2'b10);
      lo = (sz != 2'b01);
      waits = (d <= 2) ? 0 : (d - 1) / 2;
      len = 8 + 2 * waits;
      @(negedge clk);
      chk(req_ready == 1'b1, "R2 ready when idle", 32'(req_ready), 1);
      req_valid = 1'b1; req_size = sz; req_addr = a; req_data = dat; req_fc = f;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < len; i++) begin
         bit as_e, ds_e, oe_e;
         as_e = (i >= 2) && (i <= len - 2);
         ds_e = (i >= 4) && (i <= len - 2);
         oe_e = (i >= 3);
         chk(req_ready == 1'b0, "R2 busy not ready", 32'(req_ready), 0);
         chk(fc_o == f, "R3 function code", 32'(fc_o), 32'(f));
         if (i >= 1) chk(addr_o == a, "R3 address", 32'(addr_o), 32'(a));
         chk(as_n == !as_e, "R3/R7 address strobe", 32'(as_n), 32'(!as_e));
         chk(rw_o == (i < 2), "R3 direction", 32'(rw_o), 32'(i < 2));
         chk(uds_n == !(ds_e && up), "R4 upper strobe", 32'(uds_n), 32'(!(ds_e && up)));
         chk(lds_n == !(ds_e && lo), "R4 lower strobe", 32'(lds_n), 32'(!(ds_e && lo)));
         chk(data_oe_hi == (oe_e && up), "R4 upper lane enable", 32'(data_oe_hi), 32'(oe_e && up));
         chk(data_oe_lo == (oe_e && lo), "R4 lower lane enable", 32'(data_oe_lo), 32'(oe_e && lo));
         if (oe_e && up) chk(data_o[15:8] == dat[15:8], "R4 upper data", 32'(data_o[15:8]), 32'(dat[15:8]));
         if (oe_e && lo) chk(data_o[7:0] == dat[7:0], "R4 lower data", 32'(data_o[7:0]), 32'(dat[7:0]));
         chk(done == (i == len - 1), "R5/R6 done timing", 32'(done), 32'(i == len - 1));
         if (i == len - 1) begin
            chk(done_err == use_err, "R8 error flag", 32'(done_err), 32'(use_err));
            chk(done_periph == periph, "R9 peripheral flag", 32'(done_periph), 32'(periph));
         end
         // stimulus for the next phase
         if (i == d) begin
            if (use_err) bus_err_n = 1'b0; else bus_ack_n = 1'b0;
         end
         if (i == 0 && periph) periph_req_n = 1'b0;
         if (inject && i == 3) begin
            req_valid = 1'b1; req_addr = ~a; req_data = ~dat;
         end
         if (inject && i == 4) req_valid = 1'b0;
         @(negedge clk);
      end
      bus_ack_n = 1'b1; bus_err_n = 1'b1; periph_req_n = 1'b1;
      chk(req_ready == 1'b1, "R2 idle after cycle", 32'(req_ready), 1);
      chk(data_oe_hi == 1'b0 && data_oe_lo == 1'b0, "R7 lanes released",
          {30'b0, data_oe_hi, data_oe_lo}, 0);
      chk(rw_o == 1'b0, "R7 direction held low", 32'(rw_o), 0);
      chk(done == 1'b0, "R5 done single", 32'(done), 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(as_n && uds_n && lds_n && rw_o, "R1 strobes and direction high",
          {28'b0, as_n, uds_n, lds_n, rw_o}, 32'hf);
      chk(!data_oe_hi && !data_oe_lo, "R1 lanes off", {30'b0, data_oe_hi, data_oe_lo}, 0);
      chk(!done && req_ready, "R1 idle ready", {30'b0, done, req_ready}, 1);
   endtask

   task automatic t_word;        run_cycle(2'b00, 23'h12_3456, 16'hbeef, 3'd5, 0, 0, 0, 0); endtask
   task automatic t_even;        run_cycle(2'b01, 23'h00_0042, 16'ha5_00, 3'd1, 1, 0, 0, 0); endtask
   task automatic t_odd;         run_cycle(2'b10, 23'h7f_fffe, 16'h00_5a, 3'd2, 2, 0, 0, 0); endtask
   task automatic t_rsvd_word;   run_cycle(2'b11, 23'h01_0101, 16'h1234, 3'd6, 0, 0, 0, 0); endtask
   task automatic t_wait_one;    run_cycle(2'b00, 23'h2a_aaaa, 16'h5555, 3'd3, 4, 0, 0, 0); endtask
   task automatic t_wait_two;    run_cycle(2'b01, 23'h15_5555, 16'hc3_00, 3'd4, 5, 0, 0, 0); endtask
   task automatic t_bus_err;     run_cycle(2'b00, 23'h33_3333, 16'h0f0f, 3'd7, 3, 1, 0, 0); endtask
   task automatic t_periph;      run_cycle(2'b10, 23'h44_4444, 16'h00_99, 3'd1, 0, 0, 1, 0); endtask
   task automatic t_busy_req;    run_cycle(2'b00, 23'h0a_bcde, 16'h6789, 3'd2, 6, 0, 0, 1); endtask

   task automatic t_back_to_back;
      run_cycle(2'b00, 23'h11_1111, 16'h1111, 3'd1, 0, 0, 0, 0);
      run_cycle(2'b01, 23'h22_2222, 16'h2200, 3'd2, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_word();
      t_even();
      t_odd();
      t_rsvd_word();
      t_wait_one();
      t_wait_two();
      t_bus_err();
      t_periph();
      t_busy_req();
      t_back_to_back();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule